// File: doc/BRIEF.md
# Decimating Multiply-Accumulate Filter Cell

This block is one tap of a cascadable FIR array. On every clock it multiplies a broadcast 9-bit input sample by the coefficient held in the cell and adds the product into a 26-bit running sum. A sample register and a coefficient register capture new operands under their own enables. Each operand carries its own format flag, so the sample and the coefficient can each be read as 8-bit unsigned or as 9-bit two's complement.

The coefficient also travels on to the next cell through a delay line. This line has a selectable depth of one to four registers. When a row of cells is chained, the extra depth makes consecutive taps see coefficients that are spaced further apart in time. This lets the output rate of the array drop by 2:1, 3:1 or 4:1. An erase input restarts the running sum: on the next clock the sum takes the current product in place of its old value.

Top module: `mac_decim_cell`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_out` and `coef_out` become zero and both operand registers are cleared to value 0 in unsigned format.
- R2: A sample captured with `data_signed`=1 is read as a 9-bit two's complement number. With `data_signed`=0 it is read as the unsigned value of bits 7:0, and bit 8 has no effect on the product.
- R3: A coefficient captured with `coef_signed`=1 is read as 9-bit two's complement, and with `coef_signed`=0 as the unsigned value of bits 7:0. This choice is independent of the sample's format.
- R4: At each clock edge with `erase`=0, `acc_out` becomes its previous value plus the product of the sample and coefficient registers as they stood before that edge. The product is sign-extended to 26 bits.
- R5: At a clock edge with `erase`=1, `acc_out` becomes exactly that same product, and the previous sum is discarded.
- R6: When `data_en` is 0 at an edge, the sample register and its format flag keep their value, so the same product keeps being added.
- R7: When `coef_en` is 0 at an edge, the coefficient register, its format flag and every delay register keep their value.
- R8: `coef_out` presents the coefficient after `dec_sel`+1 captures: `dec_sel`=0 gives the value of `coef_in` at the latest edge with `coef_en`=1, and `dec_sel`=1, 2 and 3 give the value one, two or three enabled captures earlier.
- R9: The sum wraps modulo 2^26 with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 9 | Broadcast input sample |
| data_en | input | 1 | Sample register capture enable |
| data_signed | input | 1 | Sample format: 1 two's complement, 0 unsigned 8-bit |
| coef_in | input | 9 | Coefficient from the previous cell |
| coef_en | input | 1 | Coefficient register and delay line capture enable |
| coef_signed | input | 1 | Coefficient format: 1 two's complement, 0 unsigned 8-bit |
| erase | input | 1 | Restart the sum with the current product |
| dec_sel | input | 2 | Coefficient delay select, 0..3 for 1..4 registers |
| coef_out | output | 9 | Delayed coefficient to the next cell |
| acc_out | output | 26 | Running sum |

## Verification
The hardest condition to reach is wraparound of the 26-bit sum. The largest single product is 65536, so a wrap only happens after more than a thousand clocks of the worst-case operands. The stimulus holds both operands at signed -256 and loads the sum with one product through erase. It then lets the sum run for 1023 more clocks and checks the value just before and just after it crosses 2^26. The delay line is exercised under each of the four select values with random gaps in the coefficient enable, so that capture order, not clock count, decides the expected tap.

// File: rtl/fcell_pkg.sv
package fcell_pkg;

    // operand width as seen at the pins
    localparam int OP_W   = 9;
    // widened operand: one extra bit so an unsigned 8-bit value stays positive
    localparam int EXT_W  = OP_W + 1;
    localparam int PROD_W = 2 * EXT_W;

    typedef struct packed {
        logic            is_signed;
        logic [OP_W-1:0] bits;
    } operand_t;

    localparam operand_t OPERAND_ZERO = '{is_signed: 1'b0, bits: '0};

    // Interpret an operand according to its captured format flag.
    function automatic logic signed [EXT_W-1:0] widen(input operand_t op);
        logic signed [EXT_W-1:0] r;
        if (op.is_signed) begin
            r = {op.bits[OP_W-1], op.bits};
        end else begin
            r = {2'b00, op.bits[OP_W-2:0]};
        end
        return r;
    endfunction

endpackage

// File: rtl/fcell_operand_reg.sv
module fcell_operand_reg
    import fcell_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  operand_t d,
    output operand_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= OPERAND_ZERO;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/fcell_coef_chain.sv
module fcell_coef_chain
    import fcell_pkg::*;
#(
    parameter int STAGES = 3,
    parameter int SEL_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [OP_W-1:0]  head,
    input  logic [SEL_W-1:0] sel,
    output logic [OP_W-1:0]  tap
);

    generate
        if (STAGES == 0) begin : g_no_delay
            assign tap = head;
        end else begin : g_delay
            logic [OP_W-1:0] dly [1:STAGES];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 1; k <= STAGES; k++) begin
                        dly[k] <= '0;
                    end
                end else if (en) begin
                    dly[1] <= head;
                    for (int k = 2; k <= STAGES; k++) begin
                        dly[k] <= dly[k-1];
                    end
                end
            end

            // select 0 taps the coefficient register itself
            always_comb begin
                tap = head;
                for (int k = 1; k <= STAGES; k++) begin
                    if (int'(sel) == k) begin
                        tap = dly[k];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fcell_mac.sv
module fcell_mac
    import fcell_pkg::*;
#(
    parameter int ACC_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  operand_t         smp,
    input  operand_t         cof,
    output logic [ACC_W-1:0] prod_ext,
    output logic [ACC_W-1:0] acc
);

    localparam int PAD_W = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] prod;

    assign prod     = widen(smp) * widen(cof);
    assign prod_ext = {{PAD_W{prod[PROD_W-1]}}, prod};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (clear) begin
            acc <= prod_ext;
        end else begin
            acc <= acc + prod_ext;
        end
    end

endmodule

// File: rtl/mac_decim_cell.sv
module mac_decim_cell
    import fcell_pkg::*;
#(
    parameter  int ACC_W      = 26,
    parameter  int DEC_STAGES = 3,
    localparam int SEL_W      = $clog2(DEC_STAGES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  din,
    input  logic             data_en,
    input  logic             data_signed,
    input  logic [OP_W-1:0]  coef_in,
    input  logic             coef_en,
    input  logic             coef_signed,
    input  logic             erase,
    input  logic [SEL_W-1:0] dec_sel,
    output logic [OP_W-1:0]  coef_out,
    output logic [ACC_W-1:0] acc_out
);

    operand_t         data_q;
    operand_t         coef_q;
    logic [ACC_W-1:0] prod_ext;

    fcell_operand_reg u_data_reg (
        .clk  (clk),
        .rst  (rst),
        .load (data_en),
        .d    ('{is_signed: data_signed, bits: din}),
        .q    (data_q)
    );

    fcell_operand_reg u_coef_reg (
        .clk  (clk),
        .rst  (rst),
        .load (coef_en),
        .d    ('{is_signed: coef_signed, bits: coef_in}),
        .q    (coef_q)
    );

    fcell_coef_chain #(
        .STAGES (DEC_STAGES),
        .SEL_W  (SEL_W)
    ) u_chain (
        .clk  (clk),
        .rst  (rst),
        .en   (coef_en),
        .head (coef_q.bits),
        .sel  (dec_sel),
        .tap  (coef_out)
    );

    fcell_mac #(
        .ACC_W (ACC_W)
    ) u_mac (
        .clk      (clk),
        .rst      (rst),
        .clear    (erase),
        .smp      (data_q),
        .cof      (coef_q),
        .prod_ext (prod_ext),
        .acc      (acc_out)
    );

endmodule

// File: rtl/mac_decim_cell_chk.sv
module mac_decim_cell_chk
    import fcell_pkg::*;
#(
    parameter int ACC_W = 26,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             data_en,
    input logic             coef_en,
    input logic             erase,
    input logic [SEL_W-1:0] dec_sel,
    input logic [OP_W-1:0]  coef_in,
    input logic [OP_W-1:0]  coef_out,
    input logic [ACC_W-1:0] acc_out,
    input logic [ACC_W-1:0] prod_ext,
    input operand_t         data_q,
    input operand_t         coef_q
);

    // R5
    erase_load_chk: assert property (@(posedge clk) disable iff (rst)
        erase |=> acc_out == $past(prod_ext));

    // R4
    accumulate_chk: assert property (@(posedge clk) disable iff (rst)
        !erase |=> acc_out == $past(acc_out) + $past(prod_ext));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !data_en |=> $stable(data_q));

    // R7
    coef_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !coef_en |=> ($stable(coef_q) && (dec_sel != $past(dec_sel) || $stable(coef_out))));

    // R8
    direct_tap_chk: assert property (@(posedge clk) disable iff (rst)
        (coef_en && dec_sel == '0) |=> (dec_sel != '0 || coef_out == $past(coef_in)));

    // R3
    unsigned_nonneg_chk: assert property (@(posedge clk) disable iff (rst)
        (!data_q.is_signed && !coef_q.is_signed) |-> !prod_ext[ACC_W-1]);

endmodule

bind mac_decim_cell mac_decim_cell_chk #(
    .ACC_W (ACC_W),
    .SEL_W (SEL_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .data_en  (data_en),
    .coef_en  (coef_en),
    .erase    (erase),
    .dec_sel  (dec_sel),
    .coef_in  (coef_in),
    .coef_out (coef_out),
    .acc_out  (acc_out),
    .prod_ext (prod_ext),
    .data_q   (data_q),
    .coef_q   (coef_q)
);

// File: tb/mac_decim_cell_tb.sv
`timescale 1ns/1ps
module mac_decim_cell_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [8:0]  din, coef_in;
    logic        data_en, data_signed, coef_en, coef_signed, erase;
    logic [1:0]  dec_sel;
    logic [8:0]  coef_out;
    logic [25:0] acc_out;

    always #2.5 clk = ~clk;

    mac_decim_cell u_dut (
        .clk(clk), .rst(rst), .din(din), .data_en(data_en), .data_signed(data_signed),
        .coef_in(coef_in), .coef_en(coef_en), .coef_signed(coef_signed),
        .erase(erase), .dec_sel(dec_sel), .coef_out(coef_out), .acc_out(acc_out)
    );

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    // reference state
    logic [8:0]  m_d, m_c;
    logic        m_ds, m_cs;
    logic [8:0]  m_dly [1:3];
    logic [25:0] m_acc;

    // {din, coef_in, data_signed, coef_signed, expected product}
    localparam logic [45:0] VEC [0:8] = '{
        {9'h003, 9'h004, 1'b0, 1'b0, 26'd12},
        {9'h1FF, 9'h002, 1'b1, 1'b1, 26'(-2)},
        {9'h1FF, 9'h002, 1'b0, 1'b0, 26'd510},
        {9'h100, 9'h100, 1'b1, 1'b1, 26'd65536},
        {9'h100, 9'h0FF, 1'b1, 1'b0, 26'(-65280)},
        {9'h0FF, 9'h1FF, 1'b0, 1'b1, 26'(-255)},
        {9'h0FF, 9'h0FF, 1'b0, 1'b0, 26'd65025},
        {9'h17F, 9'h07F, 1'b1, 1'b1, 26'(-16383)},
        {9'h180, 9'h003, 1'b0, 1'b1, 26'd384}
    };

    function automatic int val(input logic [8:0] b, input logic s);
        return s ? int'($signed(b)) : int'(b[7:0]);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        logic [25:0] p;
        if (rst) begin
            m_d = '0; m_c = '0; m_ds = 1'b0; m_cs = 1'b0; m_acc = '0;
            for (int k = 1; k <= 3; k++) m_dly[k] = '0;
        end else begin
            p = 26'(val(m_d, m_ds) * val(m_c, m_cs));
            m_acc = erase ? p : m_acc + p;
            if (coef_en) begin
                m_dly[3] = m_dly[2]; m_dly[2] = m_dly[1]; m_dly[1] = m_c;
                m_c = coef_in; m_cs = coef_signed;
            end
            if (data_en) begin
                m_d = din; m_ds = data_signed;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [8:0] exp_tap();
        return (dec_sel == 2'd0) ? m_c : m_dly[int'(dec_sel)];
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; din = '0; coef_in = '0; data_en = 1'b0; coef_en = 1'b0;
        data_signed = 1'b0; coef_signed = 1'b0; erase = 1'b0; dec_sel = 2'd0;
        step(); step();
        rst = 1'b0;
        // R1: reset state
        chk(acc_out == 26'd0, "R1 acc after reset", 32'(acc_out), 0);
        chk(coef_out == 9'd0, "R1 coef_out after reset", 32'(coef_out), 0);

        // R2 R3 R5: table of formats, each product loaded by erase
        for (int i = 0; i < 9; i++) begin
            {din, coef_in, data_signed, coef_signed} = VEC[i][45:26];
            data_en = 1'b1; coef_en = 1'b1; erase = 1'b0;
            step();
            data_en = 1'b0; coef_en = 1'b0; erase = 1'b1;
            step();
            chk(acc_out == VEC[i][25:0], "R2 R3 R5 format product", 32'(acc_out), 32'(VEC[i][25:0]));
        end

        // R2: bit 8 ignored in unsigned mode
        din = 9'h1A5; coef_in = 9'h003; data_signed = 1'b0; coef_signed = 1'b0;
        data_en = 1'b1; coef_en = 1'b1; erase = 1'b0;
        step();
        erase = 1'b1; data_en = 1'b0; coef_en = 1'b0;
        step();
        chk(acc_out == 26'd495, "R2 unsigned bit8 ignored", 32'(acc_out), 495);

        // R4 R6 R7: enables low, new inputs do not enter
        din = 9'h002; coef_in = 9'h003; data_en = 1'b1; coef_en = 1'b1; erase = 1'b0;
        step();
        erase = 1'b1; data_en = 1'b0; coef_en = 1'b0; din = 9'd100; coef_in = 9'd77;
        step();
        erase = 1'b0;
        step(); step();
        chk(acc_out == 26'd18, "R4 R6 held sample accumulates", 32'(acc_out), 18);
        chk(coef_out == 9'd3, "R7 coefficient held", 32'(coef_out), 3);

        // R9: wraparound of the sum
        din = 9'h100; coef_in = 9'h100; data_signed = 1'b1; coef_signed = 1'b1;
        data_en = 1'b1; coef_en = 1'b1;
        step();
        data_en = 1'b0; coef_en = 1'b0; erase = 1'b1;
        step();
        erase = 1'b0;
        for (int i = 0; i < 1022; i++) step();
        chk(acc_out == 26'h3FF0000, "R9 sum before wrap", 32'(acc_out), 32'h3FF0000);
        step();
        chk(acc_out == 26'd0, "R9 sum after wrap", 32'(acc_out), 0);

        // R4 R8: random run over all delay selects and format pairs
        for (int sel = 0; sel < 4; sel++) begin
            for (int fmt = 0; fmt < 4; fmt++) begin
                dec_sel = 2'(sel);
                data_signed = fmt[0]; coef_signed = fmt[1];
                for (int n = 0; n < 40; n++) begin
                    din = 9'($urandom); coef_in = 9'($urandom);
                    data_en = ($urandom % 4) != 0;
                    coef_en = ($urandom % 3) != 0;
                    erase = ($urandom % 16) == 0;
                    step();
                    chk(acc_out == m_acc, "R4 random sum", 32'(acc_out), 32'(m_acc));
                    chk(coef_out == exp_tap(), "R8 delayed coefficient", 32'(coef_out), 32'(exp_tap()));
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule